// File: doc/BRIEF.md
# One-Time-Programmable Memory Write Sequencer

This block carries out the byte-at-a-time write protocol of a fuse-style memory that has two fields. The data field holds 128 bytes in four 32-byte pages. The status field holds 8 bytes. A master streams in a command byte, a 16-bit target address (low byte first) and one data byte, which lands in a scratchpad. It then reads back a 16-bit check value computed over what it sent. If that value is correct, the master raises a programming strobe. This strobe stands in for the high-voltage detector. The addressed byte is then ANDed with the scratchpad, so programming can only clear bits. The block returns the stored byte for verification and advances to the next address. For every later byte, the master sends only data. The check value of each later pass starts from the new address instead of covering the command again.

Bytes move through two valid/ready streams. The input stream carries master-to-block bytes. The output stream carries check bytes and verify bytes. A byte is transferred on a clock edge where both valid and ready are high. The block lowers its input ready while it has output pending or is waiting for the strobe. It holds output data steady for as long as valid is high and ready is low. A synchronous `bus_reset` stands for the line reset pulse and abandons the sequence at any point. A combinational peek port reads either field at any address.

Top module: `otp_wr_seq`

## Requirements
- R1: After `rst_n` every byte of both fields reads FFh. `rx_ready` is 1 and `tx_valid` is 0.
- R2: First pass: the block sends the one's complement of a CRC-16 (polynomial x^16+x^15+x^2+1, reflected form A001h, LSB first per byte, start value 0000h). The CRC covers the command, address low, address high and data bytes, in that order. The low byte goes out first, then the high byte.
- R3: A strobe on `prog_pulse` in the waiting state sets the addressed byte to its old value ANDed with the scratchpad. The next output byte is that stored value.
- R4: Between the second check byte and the strobe, `tx_valid` and `rx_ready` are both 0.
- R5: Once the verify byte is taken, the address always advances by one. The next pass takes only a data byte. Its check value starts from the new 16-bit address and shifts in that data byte alone.
- R6: A data-field byte in a page whose protect bit is 0 keeps its value after a strobe. The protect bit is bit p of status byte 0 for page p = address bits 6:5. The verify byte returns the unchanged value.
- R7: `bus_reset` returns the block to expect a command within one cycle. A strobe that follows it changes no memory.
- R8: A command other than 0Fh (data field) or 55h (status field) causes every following byte to be consumed with no output until `bus_reset`.
- R9: Status address 7 is volatile. A write there replaces the byte with the scratchpad, including setting bits, and needs no strobe. The verify byte follows the check bytes at once.
- R10: A start address at or past the end of its field, or an advance past the end, causes later bytes to be consumed with no output and no programming until `bus_reset`.
- R11: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` is stable on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; fields return to all ones |
| bus_reset | input | 1 | Synchronous sequence abort |
| rx_valid | input | 1 | Input byte valid |
| rx_ready | output | 1 | Block accepts an input byte |
| rx_data | input | 8 | Input byte |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Master accepts an output byte |
| tx_data | output | 8 | Check or verify byte |
| prog_pulse | input | 1 | Programming strobe |
| peek_st | input | 1 | Peek selects status field when 1 |
| peek_addr | input | 7 | Peek byte address |
| peek_data | output | 8 | Peeked byte |

## Verification
The bench builds the block with its default sizes: a 128-byte data field of four 32-byte pages and an 8-byte status field. At these sizes both field ends can be reached directly. These are the last data byte, address 127, and the volatile status byte, address 7. Every page index can be protected from status byte 0. Random multi-byte chains exercise the address-seeded check values. Directed cases cover protection, aborts, bad commands, out-of-range starts and output back-pressure.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [15:0] CRC_POLY_REF = 16'hA001;

  typedef enum logic [1:0] {CRC_HOLD, CRC_RESTART, CRC_SHIFT, CRC_LOAD} crc_op_e;

  typedef enum logic [3:0] {
    S_CMD, S_ALO, S_AHI, S_DATA, S_CRCL, S_CRCH, S_WAIT, S_VER, S_DEAD
  } seq_st_e;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY_REF;
    end
    return r;
  endfunction
endpackage

// File: rtl/otp_wr_crc.sv
module otp_wr_crc
  import otp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  crc_op_e     op,
  input  logic [7:0]  din,
  input  logic [15:0] seed,
  output logic [15:0] crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else begin
      case (op)
        CRC_RESTART: crc_q <= crc_step(16'h0000, din);
        CRC_SHIFT:   crc_q <= crc_step(crc_q, din);
        CRC_LOAD:    crc_q <= seed;
        default:     crc_q <= crc_q;
      endcase
    end
  end
endmodule

// File: rtl/otp_wr_array.sv
module otp_wr_array #(
  parameter int DATA_BYTES = 128,
  parameter int STAT_BYTES = 8,
  parameter int PAGE_BYTES = 32,
  localparam int DA_W = $clog2(DATA_BYTES),
  localparam int SA_W = $clog2(STAT_BYTES),
  localparam int PG_W = $clog2(PAGE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_vol,
  input  logic [7:0]      wr_data,
  input  logic            sel_st,
  input  logic [DA_W-1:0] sel_addr,
  output logic [7:0]      sel_byte,
  input  logic            peek_st,
  input  logic [DA_W-1:0] peek_addr,
  output logic [7:0]      peek_byte
);
  logic [7:0] dmem [DATA_BYTES];
  logic [7:0] smem [STAT_BYTES];
  logic       prot_hit;
  logic       do_wr;
  logic [DA_W-PG_W-1:0] page;

  assign page     = sel_addr[DA_W-1:PG_W];
  assign prot_hit = !sel_st && !smem[0][page];
  assign do_wr    = wr_en && !prot_hit;

  assign sel_byte  = sel_st  ? smem[sel_addr[SA_W-1:0]]  : dmem[sel_addr];
  assign peek_byte = peek_st ? smem[peek_addr[SA_W-1:0]] : dmem[peek_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_BYTES; i++) dmem[i] <= 8'hFF;
      for (int j = 0; j < STAT_BYTES; j++) smem[j] <= 8'hFF;
    end else if (do_wr) begin
      if (sel_st) begin
        if (wr_vol) smem[sel_addr[SA_W-1:0]] <= wr_data;
        else        smem[sel_addr[SA_W-1:0]] <= smem[sel_addr[SA_W-1:0]] & wr_data;
      end else begin
        dmem[sel_addr] <= dmem[sel_addr] & wr_data;
      end
    end
  end

  // R3
  prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_vol && !prot_hit) |=> (sel_byte == ($past(sel_byte) & $past(wr_data))));

  // R6
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prot_hit) |=> $stable(sel_byte));
endmodule

// File: rtl/otp_wr_seq.sv
module otp_wr_seq
  import otp_pkg::*;
#(
  parameter int         DATA_BYTES = 128,
  parameter int         STAT_BYTES = 8,
  parameter int         PAGE_BYTES = 32,
  parameter logic [7:0] CMD_DATA   = 8'h0F,
  parameter logic [7:0] CMD_STAT   = 8'h55
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_reset,
  input  logic                          rx_valid,
  output logic                          rx_ready,
  input  logic [7:0]                    rx_data,
  output logic                          tx_valid,
  input  logic                          tx_ready,
  output logic [7:0]                    tx_data,
  input  logic                          prog_pulse,
  input  logic                          peek_st,
  input  logic [$clog2(DATA_BYTES)-1:0] peek_addr,
  output logic [7:0]                    peek_data
);
  localparam int          DA_W = $clog2(DATA_BYTES);
  localparam logic [16:0] DLIM = 17'(DATA_BYTES);
  localparam logic [16:0] SLIM = 17'(STAT_BYTES);

  seq_st_e     state;
  logic        field_st;
  logic [15:0] addr;
  logic [7:0]  scratch;
  logic        rx_fire, tx_fire;
  logic [16:0] lim, next_addr;
  logic        vol_hit, wr_en;
  crc_op_e     crc_op;
  logic [15:0] crc_q;
  logic [7:0]  sel_byte;

  assign rx_ready  = state inside {S_CMD, S_ALO, S_AHI, S_DATA, S_DEAD};
  assign tx_valid  = state inside {S_CRCL, S_CRCH, S_VER};
  assign rx_fire   = rx_valid && rx_ready;
  assign tx_fire   = tx_valid && tx_ready;
  assign lim       = field_st ? SLIM : DLIM;
  assign next_addr = {1'b0, addr} + 17'd1;
  assign vol_hit   = field_st && ({1'b0, addr} == SLIM - 17'd1);
  assign wr_en     = (state == S_CRCH && tx_fire && vol_hit) ||
                     (state == S_WAIT && prog_pulse);

  always_comb begin
    crc_op = CRC_HOLD;
    case (state)
      S_CMD:                  if (rx_fire) crc_op = CRC_RESTART;
      S_ALO, S_AHI, S_DATA:   if (rx_fire) crc_op = CRC_SHIFT;
      S_VER:                  if (tx_fire && next_addr < lim) crc_op = CRC_LOAD;
      default:                crc_op = CRC_HOLD;
    endcase
  end

  always_comb begin
    case (state)
      S_CRCL:  tx_data = ~crc_q[7:0];
      S_CRCH:  tx_data = ~crc_q[15:8];
      S_VER:   tx_data = sel_byte;
      default: tx_data = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_CMD;
      field_st <= 1'b0;
      addr     <= '0;
      scratch  <= 8'hFF;
    end else if (bus_reset) begin
      state <= S_CMD;
    end else begin
      case (state)
        S_CMD: if (rx_fire) begin
          if (rx_data == CMD_DATA)      begin field_st <= 1'b0; state <= S_ALO; end
          else if (rx_data == CMD_STAT) begin field_st <= 1'b1; state <= S_ALO; end
          else                          state <= S_DEAD;
        end
        S_ALO: if (rx_fire) begin addr[7:0] <= rx_data; state <= S_AHI; end
        S_AHI: if (rx_fire) begin
          addr[15:8] <= rx_data;
          state <= ({1'b0, rx_data, addr[7:0]} < lim) ? S_DATA : S_DEAD;
        end
        S_DATA: if (rx_fire) begin scratch <= rx_data; state <= S_CRCL; end
        S_CRCL: if (tx_fire) state <= S_CRCH;
        S_CRCH: if (tx_fire) state <= vol_hit ? S_VER : S_WAIT;
        S_WAIT: if (prog_pulse) state <= S_VER;
        S_VER: if (tx_fire) begin
          if (next_addr < lim) begin addr <= next_addr[15:0]; state <= S_DATA; end
          else state <= S_DEAD;
        end
        default: state <= S_DEAD;
      endcase
    end
  end

  otp_wr_crc u_crc (
    .clk(clk), .rst_n(rst_n), .op(crc_op), .din(rx_data),
    .seed(next_addr[15:0]), .crc_q(crc_q)
  );

  otp_wr_array #(
    .DATA_BYTES(DATA_BYTES), .STAT_BYTES(STAT_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_vol(vol_hit), .wr_data(scratch),
    .sel_st(field_st), .sel_addr(addr[DA_W-1:0]), .sel_byte(sel_byte),
    .peek_st(peek_st), .peek_addr(peek_addr), .peek_byte(peek_data)
  );

  // R11
  tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (rx_ready && !tx_valid));

  // R4
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    ($past(state) == S_CRCH && $past(tx_fire) && !$past(vol_hit)) |-> (!tx_valid && !rx_ready));
endmodule

// File: tb/sim_otp_wr_seq.sv
module sim_otp_wr_seq;
  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b0, prog_pulse = 1'b0, peek_st = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [6:0] peek_addr = '0;
  logic rx_ready, tx_valid;
  logic [7:0] tx_data, peek_data;
  int tests = 0, fails = 0;
  logic [7:0] dmem [128];
  logic [7:0] smem [8];

  always #2.5 clk = ~clk;

  otp_wr_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .prog_pulse(prog_pulse), .peek_st(peek_st),
    .peek_addr(peek_addr), .peek_data(peek_data)
  );

  function automatic logic [15:0] crcu(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b, output bit got);
    int n = 0;
    tx_ready = 1'b1;
    while (!tx_valid && n < 10) begin @(negedge clk); n++; end
    got = tx_valid; b = tx_data;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic pulse();
    prog_pulse = 1'b1; @(negedge clk); prog_pulse = 1'b0;
  endtask

  task automatic breset();
    bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic peek_chk(input bit st, input int a, input string rq);
    logic [7:0] e;
    peek_st = st; peek_addr = 7'(a); #1;
    e = st ? smem[a] : dmem[a];
    chk(peek_data === e, rq, {8'h0, peek_data}, {8'h0, e});
  endtask

  task automatic one_pass(input bit first, input bit st, input logic [15:0] a,
                          input logic [7:0] d, input bit hold);
    logic [15:0] c;
    logic [7:0] lo, hi, b, e, v0;
    bit got, vol, prot;
    if (first) begin
      c = crcu(16'h0000, st ? 8'h55 : 8'h0F); send(st ? 8'h55 : 8'h0F);
      c = crcu(c, a[7:0]);  send(a[7:0]);
      c = crcu(c, a[15:8]); send(a[15:8]);
    end else c = a;
    c = crcu(c, d); send(d);
    if (hold) begin
      v0 = tx_data;
      repeat (3) @(negedge clk);
      chk(tx_valid && tx_data === v0, "R11", {8'h0, tx_data}, {8'h0, v0});
    end
    recv(lo, got);
    chk(got && lo === ~c[7:0], first ? "R2" : "R5", {8'h0, lo}, {8'h0, ~c[7:0]});
    recv(hi, got);
    chk(got && hi === ~c[15:8], first ? "R2" : "R5", {8'h0, hi}, {8'h0, ~c[15:8]});
    vol  = st && a == 16'd7;
    prot = !st && !smem[0][a[6:5]];
    if (!vol) begin
      repeat (2) @(negedge clk);
      chk(!tx_valid && !rx_ready, "R4", {14'h0, tx_valid, rx_ready}, 16'h0);
      pulse();
    end
    if (st) smem[a[2:0]] = vol ? d : (smem[a[2:0]] & d);
    else if (!prot) dmem[a[6:0]] = dmem[a[6:0]] & d;
    e = st ? smem[a[2:0]] : dmem[a[6:0]];
    recv(b, got);
    chk(got && b === e, vol ? "R9" : (prot ? "R6" : "R3"), {8'h0, b}, {8'h0, e});
  endtask

  task automatic xact(input bit st, input int a, input int n);
    for (int k = 0; k < n; k++) one_pass(k == 0, st, 16'(a + k), 8'($urandom), 1'b0);
    breset();
  endtask

  task automatic expect_silent(input string rq);
    logic [7:0] b; bit got;
    recv(b, got);
    chk(!got, rq, {15'h0, got}, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 128; i++) dmem[i] = 8'hFF;
    for (int i = 0; i < 8; i++) smem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rx_ready && !tx_valid, "R1", {14'h0, rx_ready, tx_valid}, 16'h2);
    peek_chk(1'b0, 0, "R1"); peek_chk(1'b0, 127, "R1"); peek_chk(1'b1, 0, "R1");

    // R2/R3/R5 directed chain with back-pressure (R11), then re-program AND
    one_pass(1'b1, 1'b0, 16'd5, 8'hA5, 1'b1);
    one_pass(1'b0, 1'b0, 16'd6, 8'h3C, 1'b0);
    breset();
    one_pass(1'b1, 1'b0, 16'd5, 8'h0F, 1'b0);
    breset();
    peek_chk(1'b0, 5, "R3");

    // random chains, R2 R3 R5
    for (int t = 0; t < 12; t++) xact(1'b0, $urandom_range(0, 120), $urandom_range(1, 3));

    // R6 protect page 1, then attempt a write there; page 0 still writable
    one_pass(1'b1, 1'b1, 16'd0, 8'hFD, 1'b0); breset();
    one_pass(1'b1, 1'b0, 16'd40, 8'h00, 1'b0); breset();
    peek_chk(1'b0, 40, "R6");
    one_pass(1'b1, 1'b0, 16'd3, 8'h00, 1'b0); breset();

    // R7 abort before the strobe
    begin
      logic [7:0] b; bit got;
      send(8'h0F); send(8'd10); send(8'd0); send(8'h00);
      recv(b, got); recv(b, got);
      breset();
      chk(rx_ready && !tx_valid, "R7", {14'h0, rx_ready, tx_valid}, 16'h2);
      pulse();
      peek_chk(1'b0, 10, "R7");
    end

    // R8 unknown command
    send(8'h33); send(8'd9); send(8'd0); send(8'h00);
    expect_silent("R8");
    pulse();
    peek_chk(1'b0, 9, "R8");
    breset();

    // R9 volatile status byte: clear then set bits, no strobe
    one_pass(1'b1, 1'b1, 16'd7, 8'h12, 1'b0); breset();
    one_pass(1'b1, 1'b1, 16'd7, 8'hFF, 1'b0); breset();
    peek_chk(1'b1, 7, "R9");

    // R10 advance past end of data field, and out-of-range start
    one_pass(1'b1, 1'b0, 16'd127, 8'h0F, 1'b0);
    send(8'h00);
    expect_silent("R10");
    pulse();
    peek_chk(1'b0, 127, "R10");
    breset();
    send(8'h0F); send(8'h80); send(8'h00); send(8'h00);
    expect_silent("R10");
    breset();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule